// File: doc/BRIEF.md
# Integer ALU with Immediate Operands

This block is the integer execute unit of a small load/store processor. It receives the raw 32-bit instruction word together with the two source register values and the program counter. A short decode stage turns the major opcode and function fields into an operation select and into operand-source choices. The operand stage then forms operand A (a register, the program counter, or zero) and operand B (a register, a sign-extended 12-bit immediate, or a 20-bit upper immediate moved into the high bits). The core computes the result.

The whole path is combinational: the result follows the inputs in the same cycle, and the surrounding pipeline registers it. The block covers wrapping add and subtract, signed and unsigned set-less-than, the three bitwise operations, the three shifts in register and immediate form, the load-upper-immediate operation and the add-upper-immediate-to-PC operation. For opcodes outside this set the block reports that it does not recognise the instruction and drives a zero result.

Instruction fields used: opcode `instr[6:0]`, function code `instr[14:12]`, alternate-operation bit `instr[30]`, short immediate `instr[31:20]`, shift amount `instr[24:20]` (the low five bits of the short immediate), and upper immediate `instr[31:12]`.

Top module: `intalu_top`

## Requirements
- R1: With opcode 0x33, function code 000 gives `rs1_val + rs2_val` when `instr[30]`=0 and `rs1_val - rs2_val` when `instr[30]`=1, both wrapping modulo 2^32.
- R2: With opcode 0x13, function code 000 gives `rs1_val` plus `instr[31:20]` sign-extended to 32 bits; `instr[30]`, being an immediate bit here, never turns this into a subtract.
- R3: With opcode 0x33, function code 010 gives 1 when `rs1_val < rs2_val` as signed numbers and 011 gives 1 when it holds as unsigned numbers; otherwise the result is 0.
- R4: With opcode 0x13, function codes 010 (signed) and 011 (unsigned) compare `rs1_val` against the sign-extended `instr[31:20]`, giving 1 or 0 as in R3.
- R5: Function codes 100, 110 and 111 give XOR, OR and AND of operand A with operand B, where B is `rs2_val` under opcode 0x33 and the sign-extended immediate under opcode 0x13.
- R6: Register shifts (opcode 0x33) use only `rs2_val[4:0]` as the amount: code 001 shifts left, code 101 shifts right logically when `instr[30]`=0 and arithmetically when `instr[30]`=1.
- R7: Immediate shifts (opcode 0x13) use `instr[24:20]` as the amount, with the same code and `instr[30]` selection as R6.
- R8: Arithmetic right shift fills vacated bits with bit 31 of operand A; logical right and left shifts fill with zeros.
- R9: Opcode 0x37 gives `{instr[31:12], 12'b0}` regardless of `rs1_val`.
- R10: Opcode 0x17 gives `pc + {instr[31:12], 12'b0}` modulo 2^32.
- R11: Any other opcode drives `op_known`=0 and `result`=0; the four opcodes above drive `op_known`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word being executed |
| pc | input | 32 | Address of the instruction |
| rs1_val | input | 32 | First source register value |
| rs2_val | input | 32 | Second source register value |
| result | output | 32 | Computed result |
| op_known | output | 1 | High when the opcode belongs to the supported set |

## Verification
The bench builds the block with its default data width of 32, which is the width every encoding above assumes, so each shift amount from 0 to 31 and each sign boundary of a 32-bit word is reachable. At that width the wrap of add, subtract and the PC-relative sum across 2^32 can be provoked directly, and the shift-amount masking is visible by feeding register amounts above 31. Signed against unsigned compares are separated by operands whose sign bits differ.

// File: rtl/intalu_pkg.sv
package intalu_pkg;

    localparam logic [6:0] OPC_REG   = 7'h33;
    localparam logic [6:0] OPC_IMM   = 7'h13;
    localparam logic [6:0] OPC_LUI   = 7'h37;
    localparam logic [6:0] OPC_AUIPC = 7'h17;

    localparam logic [2:0] F3_ADD  = 3'b000;
    localparam logic [2:0] F3_SLL  = 3'b001;
    localparam logic [2:0] F3_SLT  = 3'b010;
    localparam logic [2:0] F3_SLTU = 3'b011;
    localparam logic [2:0] F3_XOR  = 3'b100;
    localparam logic [2:0] F3_SR   = 3'b101;
    localparam logic [2:0] F3_OR   = 3'b110;
    localparam logic [2:0] F3_AND  = 3'b111;

    typedef enum logic [3:0] {
        ALU_ADD, ALU_SUB, ALU_SLT, ALU_SLTU, ALU_XOR,
        ALU_OR, ALU_AND, ALU_SLL, ALU_SRL, ALU_SRA
    } alu_op_e;

    typedef enum logic [1:0] { A_RS1, A_PC, A_ZERO } a_src_e;
    typedef enum logic [1:0] { B_RS2, B_IMM12, B_UPPER } b_src_e;

    typedef struct packed {
        logic    known;
        alu_op_e op;
        a_src_e  a_src;
        b_src_e  b_src;
    } alu_ctrl_t;

endpackage

// File: rtl/intalu_decode.sv
module intalu_decode
    import intalu_pkg::*;
(
    input  logic [6:0] opcode,
    input  logic [2:0] funct3,
    input  logic       alt_bit,
    output alu_ctrl_t  ctrl
);

    alu_ctrl_t ctrl_d;
    alu_op_e   f3_op_d;

    // Operation picked by the function code, shared by both forms
    always_comb begin
        unique case (funct3)
            F3_ADD:  f3_op_d = ALU_ADD;
            F3_SLL:  f3_op_d = ALU_SLL;
            F3_SLT:  f3_op_d = ALU_SLT;
            F3_SLTU: f3_op_d = ALU_SLTU;
            F3_XOR:  f3_op_d = ALU_XOR;
            F3_SR:   f3_op_d = alt_bit ? ALU_SRA : ALU_SRL;
            F3_OR:   f3_op_d = ALU_OR;
            default: f3_op_d = ALU_AND;
        endcase
    end

    always_comb begin
        ctrl_d       = '0;
        ctrl_d.op    = ALU_ADD;
        ctrl_d.a_src = A_ZERO;
        ctrl_d.b_src = B_RS2;
        case (opcode)
            OPC_REG: begin
                ctrl_d.known = 1'b1;
                ctrl_d.a_src = A_RS1;
                ctrl_d.b_src = B_RS2;
                ctrl_d.op    = (funct3 == F3_ADD && alt_bit) ? ALU_SUB : f3_op_d;
            end
            OPC_IMM: begin
                ctrl_d.known = 1'b1;
                ctrl_d.a_src = A_RS1;
                ctrl_d.b_src = B_IMM12;
                ctrl_d.op    = f3_op_d;
            end
            OPC_LUI: begin
                ctrl_d.known = 1'b1;
                ctrl_d.a_src = A_ZERO;
                ctrl_d.b_src = B_UPPER;
                ctrl_d.op    = ALU_ADD;
            end
            OPC_AUIPC: begin
                ctrl_d.known = 1'b1;
                ctrl_d.a_src = A_PC;
                ctrl_d.b_src = B_UPPER;
                ctrl_d.op    = ALU_ADD;
            end
            default: ctrl_d.known = 1'b0;
        endcase
    end

    assign ctrl = ctrl_d;

    // R2
    always_comb begin
        if (!$isunknown({opcode, funct3})) begin
            imm_no_sub_chk: assert (!(opcode == OPC_IMM && ctrl.op == ALU_SUB))
                else $error("immediate form selected subtract");
        end
    end

endmodule

// File: rtl/intalu_operands.sv
module intalu_operands
    import intalu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  a_src_e            a_src,
    input  b_src_e            b_src,
    input  logic [19:0]       upper_field,
    input  logic [XLEN-1:0]   rs1_val,
    input  logic [XLEN-1:0]   rs2_val,
    input  logic [XLEN-1:0]   pc,
    output logic [XLEN-1:0]   opa,
    output logic [XLEN-1:0]   opb
);

    localparam int IMM_W   = 12;
    localparam int UP_W    = 20;
    localparam int UP_SHFT = 12;

    logic [IMM_W-1:0] imm12;
    logic [XLEN-1:0]  imm_sx_d;
    logic [XLEN-1:0]  upper_d;

    assign imm12    = upper_field[UP_W-1 -: IMM_W];
    assign imm_sx_d = {{(XLEN-IMM_W){imm12[IMM_W-1]}}, imm12};

    generate
        if (XLEN > UP_W + UP_SHFT) begin : g_upper_wide
            assign upper_d = {{(XLEN-UP_W-UP_SHFT){upper_field[UP_W-1]}},
                              upper_field, {UP_SHFT{1'b0}}};
        end else begin : g_upper_exact
            assign upper_d = {upper_field, {UP_SHFT{1'b0}}};
        end
    endgenerate

    always_comb begin
        unique case (a_src)
            A_RS1:   opa = rs1_val;
            A_PC:    opa = pc;
            default: opa = '0;
        endcase
    end

    always_comb begin
        unique case (b_src)
            B_RS2:   opb = rs2_val;
            B_IMM12: opb = imm_sx_d;
            default: opb = upper_d;
        endcase
    end

    // R9
    always_comb begin
        if (!$isunknown({a_src, b_src})) begin
            upper_zero_low_chk: assert (!(b_src == B_UPPER) || opb[UP_SHFT-1:0] == '0)
                else $error("upper immediate has nonzero low bits");
        end
    end

endmodule

// File: rtl/intalu_core.sv
module intalu_core
    import intalu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  alu_op_e          op,
    input  logic [XLEN-1:0]  opa,
    input  logic [XLEN-1:0]  opb,
    output logic [XLEN-1:0]  res
);

    localparam int SHW = $clog2(XLEN);

    logic [SHW-1:0]  shamt;
    logic [XLEN-1:0] sum_d;
    logic [XLEN-1:0] diff_d;
    logic            lt_s_d;
    logic            lt_u_d;
    logic [XLEN-1:0] res_d;

    assign shamt  = opb[SHW-1:0];
    assign sum_d  = opa + opb;
    assign diff_d = opa - opb;
    assign lt_s_d = $signed(opa) < $signed(opb);
    assign lt_u_d = opa < opb;

    always_comb begin
        unique case (op)
            ALU_ADD:  res_d = sum_d;
            ALU_SUB:  res_d = diff_d;
            ALU_SLT:  res_d = {{(XLEN-1){1'b0}}, lt_s_d};
            ALU_SLTU: res_d = {{(XLEN-1){1'b0}}, lt_u_d};
            ALU_XOR:  res_d = opa ^ opb;
            ALU_OR:   res_d = opa | opb;
            ALU_AND:  res_d = opa & opb;
            ALU_SLL:  res_d = opa << shamt;
            ALU_SRL:  res_d = opa >> shamt;
            ALU_SRA:  res_d = XLEN'($signed(opa) >>> shamt);
            default:  res_d = '0;
        endcase
    end

    assign res = res_d;

    always_comb begin
        if (!$isunknown({op, opa, opb})) begin
            // R3
            slt_bool_chk: assert (!(op == ALU_SLT || op == ALU_SLTU) || res[XLEN-1:1] == '0)
                else $error("compare result wider than one bit");
            // R8
            sra_sign_fill_chk: assert (!(op == ALU_SRA && opa[XLEN-1]) || res[XLEN-1])
                else $error("arithmetic shift lost the sign");
            // R8
            srl_zero_fill_chk: assert (!(op == ALU_SRL && shamt != '0) || !res[XLEN-1])
                else $error("logical right shift filled with one");
            // R1
            sub_inverse_chk: assert (!(op == ALU_SUB) || (res + opb) == opa)
                else $error("difference does not add back");
        end
    end

endmodule

// File: rtl/intalu_top.sv
module intalu_top
    import intalu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [31:0]      instr,
    input  logic [XLEN-1:0]  pc,
    input  logic [XLEN-1:0]  rs1_val,
    input  logic [XLEN-1:0]  rs2_val,
    output logic [XLEN-1:0]  result,
    output logic             op_known
);

    alu_ctrl_t       ctrl;
    logic [XLEN-1:0] opa;
    logic [XLEN-1:0] opb;
    logic [XLEN-1:0] core_res;
    logic [4:0]      unused_rd;

    assign unused_rd = instr[11:7];

    intalu_decode u_decode (
        .opcode  (instr[6:0]),
        .funct3  (instr[14:12]),
        .alt_bit (instr[30]),
        .ctrl    (ctrl)
    );

    intalu_operands #(.XLEN(XLEN)) u_operands (
        .a_src       (ctrl.a_src),
        .b_src       (ctrl.b_src),
        .upper_field (instr[31:12]),
        .rs1_val     (rs1_val),
        .rs2_val     (rs2_val),
        .pc          (pc),
        .opa         (opa),
        .opb         (opb)
    );

    intalu_core #(.XLEN(XLEN)) u_core (
        .op  (ctrl.op),
        .opa (opa),
        .opb (opb),
        .res (core_res)
    );

    assign op_known = ctrl.known;
    assign result   = ctrl.known ? core_res : '0;

    always_comb begin
        if (!$isunknown({instr, pc, rs1_val, rs2_val})) begin
            // R9
            lui_low_clear_chk: assert (!(instr[6:0] == OPC_LUI) || result[11:0] == '0)
                else $error("load-upper result has low bits set");
            // R10
            auipc_low_pass_chk: assert (!(instr[6:0] == OPC_AUIPC) || result[11:0] == pc[11:0])
                else $error("pc-relative result changed low pc bits");
        end
    end

endmodule

// File: tb/intalu_top_tb.sv
module intalu_top_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic [31:0] instr, pc, rs1_val, rs2_val;
    logic [31:0] result;
    logic        op_known;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    intalu_top u_dut (
        .instr    (instr),
        .pc       (pc),
        .rs1_val  (rs1_val),
        .rs2_val  (rs2_val),
        .result   (result),
        .op_known (op_known)
    );

    function automatic logic [31:0] rform(input logic alt, input logic [2:0] f3);
        return {1'b0, alt, 5'd0, 5'd2, 5'd1, f3, 5'd3, 7'h33};
    endfunction

    function automatic logic [31:0] iform(input logic [11:0] imm, input logic [2:0] f3);
        return {imm, 5'd1, f3, 5'd3, 7'h13};
    endfunction

    function automatic logic [31:0] uform(input logic [6:0] opc, input logic [19:0] imm);
        return {imm, 5'd3, opc};
    endfunction

    task automatic apply(input logic [31:0] i, input logic [31:0] a,
                         input logic [31:0] b, input logic [31:0] p);
        @(negedge clk);
        instr = i; rs1_val = a; rs2_val = b; pc = p;
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic t_reset_state;
        apply(32'h0, 32'h0, 32'h0, 32'h0);
        chk("R11 idle result", result, 32'h0);
        chk("R11 idle known", {31'b0, op_known}, 32'h0);
    endtask

    task automatic t_add_sub;
        apply(rform(1'b0, 3'b000), 32'hFFFF_FFFF, 32'h1, 32'h0);
        chk("R1 add wrap", result, 32'h0);
        chk("R11 reg known", {31'b0, op_known}, 32'h1);
        apply(rform(1'b1, 3'b000), 32'h3, 32'h5, 32'h0);
        chk("R1 sub negative", result, 32'hFFFF_FFFE);
        apply(rform(1'b1, 3'b000), 32'h8000_0000, 32'h1, 32'h0);
        chk("R1 sub wrap", result, 32'h7FFF_FFFF);
    endtask

    task automatic t_add_imm;
        apply(iform(12'h800, 3'b000), 32'h1000, 32'hDEAD, 32'h0);
        chk("R2 addi negative imm", result, 32'h800);
        apply(iform(12'h400, 3'b000), 32'hA, 32'h0, 32'h0);
        chk("R2 addi bit30 not sub", result, 32'h40A);
    endtask

    task automatic t_compare_reg;
        apply(rform(1'b0, 3'b010), 32'hFFFF_FFFF, 32'h1, 32'h0);
        chk("R3 slt signed", result, 32'h1);
        apply(rform(1'b0, 3'b011), 32'hFFFF_FFFF, 32'h1, 32'h0);
        chk("R3 sltu unsigned", result, 32'h0);
        apply(rform(1'b0, 3'b010), 32'h7, 32'h7, 32'h0);
        chk("R3 slt equal", result, 32'h0);
    endtask

    task automatic t_compare_imm;
        apply(iform(12'hFFF, 3'b010), 32'h5, 32'h0, 32'h0);
        chk("R4 slti vs -1", result, 32'h0);
        apply(iform(12'hFFF, 3'b011), 32'h5, 32'h0, 32'h0);
        chk("R4 sltiu sign-extended", result, 32'h1);
        apply(iform(12'hFFF, 3'b011), 32'hFFFF_FFFF, 32'h0, 32'h0);
        chk("R4 sltiu equal", result, 32'h0);
    endtask

    task automatic t_logic;
        apply(rform(1'b0, 3'b111), 32'hF0F0_1234, 32'hFF00_FF00, 32'h0);
        chk("R5 and reg", result, 32'hF000_1200);
        apply(rform(1'b0, 3'b110), 32'hF0F0_1234, 32'h0F00_0001, 32'h0);
        chk("R5 or reg", result, 32'hFFF0_1235);
        apply(iform(12'hFFF, 3'b100), 32'h1234_5678, 32'h0, 32'h0);
        chk("R5 xori invert", result, 32'hEDCB_A987);
        apply(iform(12'h0F0, 3'b111), 32'hFFFF_FFFF, 32'h0, 32'h0);
        chk("R5 andi", result, 32'h0000_00F0);
    endtask

    task automatic t_shift_reg;
        apply(rform(1'b0, 3'b001), 32'h1, 32'hFFFF_FFE3, 32'h0);
        chk("R6 sll masked amount", result, 32'h8);
        apply(rform(1'b0, 3'b101), 32'h8000_0000, 32'h23, 32'h0);
        chk("R8 srl zero fill", result, 32'h1000_0000);
        apply(rform(1'b1, 3'b101), 32'h8000_0000, 32'h23, 32'h0);
        chk("R8 sra sign fill", result, 32'hF000_0000);
        apply(rform(1'b1, 3'b101), 32'h4000_0000, 32'h20, 32'h0);
        chk("R6 sra amount 32 masks to 0", result, 32'h4000_0000);
    endtask

    task automatic t_shift_imm;
        apply(iform(12'h01F, 3'b001), 32'h3, 32'h0, 32'h0);
        chk("R7 slli 31", result, 32'h8000_0000);
        apply(iform(12'h41F, 3'b101), 32'h8000_0000, 32'h0, 32'h0);
        chk("R7 srai 31", result, 32'hFFFF_FFFF);
        apply(iform(12'h01F, 3'b101), 32'h8000_0000, 32'h0, 32'h0);
        chk("R7 srli 31", result, 32'h1);
    endtask

    task automatic t_upper;
        apply(uform(7'h37, 20'hABCDE), 32'h5555_5555, 32'h1, 32'h0);
        chk("R9 lui", result, 32'hABCD_E000);
        apply(uform(7'h17, 20'hFFFFF), 32'h1234, 32'h0, 32'h0000_1000);
        chk("R10 auipc wrap", result, 32'h0);
        apply(uform(7'h17, 20'h00002), 32'h0, 32'h0, 32'h0000_0ABC);
        chk("R10 auipc", result, 32'h0000_2ABC);
    endtask

    task automatic t_unknown;
        apply({20'hFFFFF, 5'd3, 7'h63}, 32'h5, 32'h6, 32'h100);
        chk("R11 unknown result", result, 32'h0);
        chk("R11 unknown flag", {31'b0, op_known}, 32'h0);
    endtask

    initial begin
        instr = '0; pc = '0; rs1_val = '0; rs2_val = '0;
        t_reset_state();
        t_add_sub();
        t_add_imm();
        t_compare_reg();
        t_compare_imm();
        t_logic();
        t_shift_reg();
        t_shift_imm();
        t_upper();
        t_unknown();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule